// File: doc/BRIEF.md
# Oversampling UART Receiver with Break Handling

This block is the receive half of an asynchronous serial port. A base-clock enable pulses at either 16 or 8 times the bit rate. A mode input picks the ratio. The receiver samples the serial line on each base tick and watches for a high-to-low transition, which it treats as the start of a frame. It then places every later sample near the centre of its bit cell. It collects a frame made of a start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit.

A character that arrives intact is offered to an external receive FIFO as a one-cycle write strobe with the data. It is dropped if the FIFO reports full. Framing, parity and line-break conditions are recorded in sticky flags that a clear input resets.

A held-low line produces one framing error, marked as a break, and writes nothing. The state machine keeps running through the break and picks up the next frame once the line has gone high and falls again. The undelayed line level is also brought out. Surrounding logic can read it to confirm that a break is still present.

Top module: `uart_os_rx`

## Requirements
- R1: A frame starts when the line was 1 at one base tick and is 0 at the next base tick, with the receiver idle; the receiver then times all samples of that frame from this tick.
- R2: With `os8_sel`=0 (16x mode), the start bit is sampled on the 8th base tick after the start tick, and each later bit 16 ticks after the one before.
- R3: With `os8_sel`=1 (8x mode), the start bit is sampled on the 4th base tick after the start tick, and each later bit 8 ticks after the one before.
- R4: The eight data bits arrive least significant bit first. When `par_en`=1 a parity bit follows them, then the stop bit. When `par_en`=0 the stop bit follows the data directly.
- R5: A frame with stop bit 1 and no parity error, received while `fifo_full`=0, gives exactly one cycle of `wr_stb`=1 with the eight data bits on `wr_data`.
- R6: With `par_en`=1 the XOR of the data and parity bits must equal `par_odd` (0 means even, 1 means odd). A mismatch sets `err_parity` and the frame is not written.
- R7: A stop bit read as 0 sets `err_frame`, and the frame is not written.
- R8: A framing error whose eight data bits are all 0 also sets `err_break`.
- R9: While the line is held low after a break frame, no write occurs. Once the line has returned high, the next falling edge starts a frame that is received normally.
- R10: A start bit that reads 1 at its centre sample is discarded as noise. No flag is set, no write occurs, and the receiver returns to idle.
- R11: A good frame that ends while `fifo_full`=1 is not written and sets no flag.
- R12: Reset clears `wr_stb` and all three flags. Once set, each flag stays set until a cycle with `err_clr`=1 clears it.
- R13: `rx_pin` always shows the present level of `rx_line`, without synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base-clock enable, one pulse per oversampling tick |
| os8_sel | input | 1 | Oversampling ratio: 0 = 16x, 1 = 8x |
| par_en | input | 1 | Parity bit present in the frame |
| par_odd | input | 1 | Parity sense: 0 = even, 1 = odd |
| rx_line | input | 1 | Serial receive line |
| fifo_full | input | 1 | Receive FIFO cannot take a write |
| err_clr | input | 1 | Clears the sticky error flags |
| wr_stb | output | 1 | One-cycle FIFO write strobe |
| wr_data | output | 8 | Character presented with the write strobe |
| err_frame | output | 1 | Sticky framing-error flag |
| err_parity | output | 1 | Sticky parity-error flag |
| err_break | output | 1 | Sticky break-detect flag |
| rx_pin | output | 1 | Undelayed view of the receive line |

## Verification
A table of frames is sent in both oversampling ratios, with and without parity and with either parity sense. Alternating and lopsided bit patterns show whether bits are sampled at the centre and stored in the right order. Frames with a flipped parity bit, a zero stop bit, or a full FIFO separate the three reasons a character is dropped and show which flag, if any, each one raises. Directed runs then send a short low glitch to test start-bit rejection, and a long all-zero line to test break marking and recovery once the line is released.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

    localparam int DATA_W = 8;
    localparam int OSR_HI = 16;
    localparam int OSR_LO = 8;
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP  = 3'd4
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              pbit;
        logic              stop;
    } rx_frame_t;

    typedef struct packed {
        logic frame;
        logic parity;
        logic brk;
    } rx_err_t;

    function automatic logic parity_mismatch(input logic [DATA_W-1:0] data,
                                             input logic pbit,
                                             input logic odd);
        return ((^data) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic rx_line,
    output logic rx_s,
    output logic fall
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            prev <= 1'b1;
        end else begin
            sh <= {sh[STAGES-2:0], rx_line};
            if (tick_en) prev <= sh[STAGES-1];
        end
    end

    assign rx_s = sh[STAGES-1];
    assign fall = tick_en & prev & ~rx_s;
endmodule

// File: rtl/uart_os_rx_timer.sv
module uart_os_rx_timer #(
    parameter int OSR_HI = 16,
    parameter int OSR_LO = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic os8,
    input  logic restart,
    input  logic run,
    output logic samp
);
    localparam int CW = $clog2(OSR_HI);
    localparam logic [CW-1:0] WRAP_HI = CW'(OSR_HI - 1);
    localparam logic [CW-1:0] WRAP_LO = CW'(OSR_LO - 1);
    localparam logic [CW-1:0] MID_HI  = CW'(OSR_HI / 2);
    localparam logic [CW-1:0] MID_LO  = CW'(OSR_LO / 2);

    logic [CW-1:0] cnt, nxt, wrap, mid;

    always_comb begin
        wrap = os8 ? WRAP_LO : WRAP_HI;
        mid  = os8 ? MID_LO : MID_HI;
        nxt  = (cnt == wrap) ? '0 : cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (tick_en && run) cnt <= nxt;
    end

    assign samp = tick_en & run & (nxt == mid);
endmodule

// File: rtl/uart_os_rx_fsm.sv
module uart_os_rx_fsm
    import uart_os_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fall,
    input  logic      samp,
    input  logic      rx_s,
    input  logic      par_en,
    output rx_state_t state,
    output logic      restart,
    output logic      run,
    output logic      frm_vld,
    output rx_frame_t frm
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              pbit;

    assign restart = (state == RX_IDLE) & fall;
    assign run     = (state != RX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            idx     <= '0;
            shreg   <= '0;
            pbit    <= 1'b0;
            frm_vld <= 1'b0;
            frm     <= '0;
        end else begin
            frm_vld <= 1'b0;
            case (state)
                RX_IDLE: if (fall) state <= RX_START;
                RX_START: if (samp) begin
                    if (rx_s) begin
                        state <= RX_IDLE;
                    end else begin
                        state <= RX_DATA;
                        idx   <= '0;
                        pbit  <= 1'b0;
                    end
                end
                RX_DATA: if (samp) begin
                    shreg <= {rx_s, shreg[DATA_W-1:1]};
                    idx   <= idx + 1'b1;
                    if (idx == LAST) state <= par_en ? RX_PAR : RX_STOP;
                end
                RX_PAR: if (samp) begin
                    pbit  <= rx_s;
                    state <= RX_STOP;
                end
                RX_STOP: if (samp) begin
                    frm_vld <= 1'b1;
                    frm     <= '{data: shreg, pbit: pbit, stop: rx_s};
                    state   <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_os_rx_eval.sv
module uart_os_rx_eval
    import uart_os_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_vld,
    input  rx_frame_t         frm,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              fifo_full,
    input  logic              err_clr,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output rx_err_t           flags
);
    logic perr, ferr, brk, good;

    always_comb begin
        perr = par_en & parity_mismatch(frm.data, frm.pbit, par_odd);
        ferr = ~frm.stop;
        brk  = ferr & (frm.data == '0);
        good = frm_vld & ~ferr & ~perr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_stb  <= 1'b0;
            wr_data <= '0;
            flags   <= '0;
        end else begin
            wr_stb <= good & ~fifo_full;
            if (good) wr_data <= frm.data;
            if (err_clr) flags <= '0;
            if (frm_vld && ferr) flags.frame  <= 1'b1;
            if (frm_vld && perr) flags.parity <= 1'b1;
            if (frm_vld && brk)  flags.brk    <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              os8_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rx_line,
    input  logic              fifo_full,
    input  logic              err_clr,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_break,
    output logic              rx_pin
);
    logic      rx_s, fall, samp, restart, run, frm_vld;
    rx_state_t state;
    rx_frame_t frm;
    rx_err_t   flags;

    uart_os_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rx_line(rx_line),
        .rx_s(rx_s), .fall(fall)
    );

    uart_os_rx_timer #(.OSR_HI(OSR_HI), .OSR_LO(OSR_LO)) i_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .os8(os8_sel),
        .restart(restart), .run(run), .samp(samp)
    );

    uart_os_rx_fsm i_fsm (
        .clk(clk), .rst(rst), .fall(fall), .samp(samp), .rx_s(rx_s),
        .par_en(par_en), .state(state), .restart(restart), .run(run),
        .frm_vld(frm_vld), .frm(frm)
    );

    uart_os_rx_eval i_eval (
        .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm(frm),
        .par_en(par_en), .par_odd(par_odd), .fifo_full(fifo_full),
        .err_clr(err_clr), .wr_stb(wr_stb), .wr_data(wr_data), .flags(flags)
    );

    assign err_frame  = flags.frame;
    assign err_parity = flags.parity;
    assign err_break  = flags.brk;
    assign rx_pin     = rx_line;
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk
    import uart_os_rx_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      tick_en,
    input logic      fifo_full,
    input logic      err_clr,
    input logic      wr_stb,
    input logic      err_frame,
    input logic      err_break,
    input logic      samp,
    input logic      fall,
    input logic      rx_s,
    input rx_state_t state
);
    AST_START_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && fall) |=> (state == RX_START)); // R1

    AST_SAMPLE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        samp |-> tick_en); // R2

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb); // R5

    AST_WR_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(!fifo_full)); // R11

    AST_NO_WR_ON_FRAME_ERR: assert property (@(posedge clk) disable iff (rst)
        $rose(err_frame) |-> !wr_stb); // R7

    AST_BREAK_WITH_FRAME: assert property (@(posedge clk) disable iff (rst)
        err_break |-> err_frame); // R8

    AST_NOISE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && samp && rx_s) |=> (state == RX_IDLE)); // R10

    AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_frame && !err_clr) |=> err_frame); // R12
endmodule

bind uart_os_rx uart_os_rx_chk i_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .fifo_full(fifo_full),
    .err_clr(err_clr), .wr_stb(wr_stb), .err_frame(err_frame),
    .err_break(err_break), .samp(samp), .fall(fall), .rx_s(rx_s),
    .state(state)
);

// File: tb/test_uart_os_rx.sv
`timescale 1ns/1ps
module test_uart_os_rx;
    localparam int TDIV = 4;
    localparam int NVEC = 8;
    // {os8, par_en, par_odd, full, bad_par, stop_bit, 2'b00, data}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h0455, 16'h84A3, 16'h440F, 16'hE401,
        16'h4C37, 16'h0081, 16'h9442, 16'hE800
    };

    logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0;
    logic os8_sel = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic rx_line = 1'b1, fifo_full = 1'b0, err_clr = 1'b0;
    logic wr_stb, err_frame, err_parity, err_break, rx_pin;
    logic [7:0] wr_data;

    int nchk = 0, nfail = 0, wr_cnt = 0, tdiv_cnt = 0;
    logic [7:0] last_data = '0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
        tick_en  <= (tdiv_cnt == TDIV - 1);
    end

    always @(negedge clk) begin
        if (wr_stb === 1'b1) begin
            wr_cnt    = wr_cnt + 1;
            last_data = wr_data;
        end
    end

    uart_os_rx i_uart_os_rx (
        .clk(clk), .rst(rst), .tick_en(tick_en), .os8_sel(os8_sel),
        .par_en(par_en), .par_odd(par_odd), .rx_line(rx_line),
        .fifo_full(fifo_full), .err_clr(err_clr), .wr_stb(wr_stb),
        .wr_data(wr_data), .err_frame(err_frame), .err_parity(err_parity),
        .err_break(err_break), .rx_pin(rx_pin)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int bit_clks();
        return (os8_sel ? 8 : 16) * TDIV;
    endfunction

    task automatic hold(input logic v, input int nbits);
        @(negedge clk) rx_line = v;
        repeat (nbits * bit_clks() - 1) @(negedge clk);
    endtask

    task automatic clear_flags();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic bad, input logic stopb);
        hold(1'b0, 1);
        for (int b = 0; b < 8; b++) hold(d[b], 1);
        if (par_en) hold((^d) ^ par_odd ^ bad, 1);
        hold(stopb, 1);
        hold(1'b1, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int w0;
        repeat (5) @(negedge clk);
        chk("R12", "wr_stb in reset", wr_stb, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "flags after reset", {err_frame, err_parity, err_break}, 0);
        hold(1'b1, 2);

        // table of frames
        for (int i = 0; i < NVEC; i++) begin
            logic exp_wr, exp_pe, exp_fe, exp_br;
            string mtag;
            os8_sel   = VEC[i][15];
            par_en    = VEC[i][14];
            par_odd   = VEC[i][13];
            fifo_full = VEC[i][12];
            clear_flags();
            w0 = wr_cnt;
            send_frame(VEC[i][7:0], VEC[i][11], VEC[i][10]);
            exp_pe = VEC[i][14] & VEC[i][11];
            exp_fe = ~VEC[i][10];
            exp_br = exp_fe & (VEC[i][7:0] == 8'h00);
            exp_wr = ~exp_pe & ~exp_fe & ~VEC[i][12];
            mtag   = os8_sel ? "R3" : "R2";
            chk(VEC[i][12] ? "R11" : "R5", $sformatf("vec %0d writes", i), wr_cnt - w0, int'(exp_wr));
            if (exp_wr) chk(mtag, $sformatf("vec %0d data R4", i), last_data, VEC[i][7:0]);
            chk("R6", $sformatf("vec %0d err_parity", i), err_parity, exp_pe);
            chk("R7", $sformatf("vec %0d err_frame", i), err_frame, exp_fe);
            chk("R8", $sformatf("vec %0d err_break", i), err_break, exp_br);
        end
        fifo_full = 1'b0;

        // R13: raw pin view, no delay
        @(negedge clk) rx_line = 1'b0;
        #1 chk("R13", "rx_pin low", rx_pin, 0);
        rx_line = 1'b1;
        #1 chk("R13", "rx_pin high", rx_pin, 1);

        // R10: short glitch rejected, then R1 resync
        os8_sel = 1'b0; par_en = 1'b0;
        hold(1'b1, 2);
        clear_flags();
        w0 = wr_cnt;
        @(negedge clk) rx_line = 1'b0;
        repeat (3 * TDIV) @(negedge clk);
        hold(1'b1, 3);
        chk("R10", "glitch writes", wr_cnt - w0, 0);
        chk("R10", "glitch flags", {err_frame, err_parity, err_break}, 0);
        send_frame(8'h3C, 1'b0, 1'b1);
        chk("R1", "frame after glitch writes", wr_cnt - w0, 1);
        chk("R1", "frame after glitch data", last_data, 8'h3C);

        // R9: long break, no writes, recovery
        clear_flags();
        w0 = wr_cnt;
        hold(1'b0, 30);
        chk("R9", "writes during break", wr_cnt - w0, 0);
        chk("R8", "break flag", err_break, 1);
        chk("R7", "frame flag on break", err_frame, 1);
        chk("R6", "no parity flag without parity", err_parity, 0);
        chk("R13", "rx_pin during break", rx_pin, 0);
        hold(1'b1, 2);
        send_frame(8'h5A, 1'b0, 1'b1);
        chk("R9", "writes after break", wr_cnt - w0, 1);
        chk("R9", "data after break", last_data, 8'h5A);
        chk("R12", "flags sticky after good frame", {err_frame, err_break}, 2'b11);
        clear_flags();
        chk("R12", "flags cleared", {err_frame, err_parity, err_break}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule